// File: doc/BRIEF.md
# Serial Character Receiver with Per-Character Error Tags

This block recovers asynchronous serial characters from a single input line. The line is sampled on a sixteen-times-baud enable supplied from outside. Each character has a start bit, five to eight data bits, an optional parity bit and a stop bit. It is stored in a small receive queue together with three error tags: framing, parity and line-break. A status word presents the tags of the character currently at the queue head, along with a sticky overrun flag. Software reads characters by popping the queue.

A line held low through a whole character (start, data, parity and stop samples all low) is a break. The receiver stores one zero character tagged as a break and then stops receiving. It resumes only after the line has gone high and a new start bit has been confirmed. Any write to the clear port, whatever its data, removes the framing, parity and break tags of the head character and clears overrun.

Top module: `uart_rx_top`

## Requirements
- R1: The line is examined only on `sampleTick` (16 per bit). A low level seen while idle is confirmed as a start bit by a second sample 8 ticks later. If that sample is high, the receiver returns to idle and stores nothing.
- R2: The data width is 5 + `wordLen` (code 0..3 gives 5..8 bits). Bits arrive least significant first, each sampled 16 ticks after the previous sample. The character is stored zero-extended on `rxData`.
- R3: With `parityEn`=1 a parity bit follows the data. With `parityStick`=0 the expected bit is the XOR of the data bits when `parityOdd`=0 (even), and its inverse when `parityOdd`=1 (odd). A mismatch sets the parity tag, which is status bit 1.
- R4: With `parityEn`=1 and `parityStick`=1 the expected parity bit is the constant 0 when `parityOdd`=0 and the constant 1 when `parityOdd`=1.
- R5: A stop sample of 0 (not a break) sets the framing tag, which is status bit 0. The received data is still stored.
- R6: When the start, data, parity and stop samples are all 0, exactly one character is stored, however long the line stays low. It has data 0x00 and the break tag set (status bit 2); its parity and framing tags are 0.
- R7: After a break, no character is accepted until the line is sampled high and a new start bit is then confirmed.
- R8: Characters leave the queue in arrival order. Status bits 2:0 always show the tags of the head character, and read 0 when the queue is empty. `rdEn` pops the head.
- R9: A character completing while the queue holds DEPTH entries is discarded. The stored entries are unchanged, and the sticky overrun flag (status bit 3) is set.
- R10: A one-cycle `errClrWr` pulse, with any `errClrData` value, clears status bits 3:0 on the next clock. The head character's data stays in place.
- R11: After reset the queue is empty and `statusWord` is 0. Bits 31:4 of `statusWord` always read 0, including after a clear write with all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-cycle enable at 16x the bit rate |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| wordLen | input | 2 | Data width code, width = 5 + code |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| parityStick | input | 1 | Parity bit is a fixed level |
| rdEn | input | 1 | Pop the head character |
| rxData | output | 8 | Head character data |
| rxEmpty | output | 1 | Queue holds no character |
| rxFull | output | 1 | Queue holds DEPTH characters |
| errClrWr | input | 1 | Write strobe of the error clear port |
| errClrData | input | 32 | Write data of the clear port, ignored |
| statusWord | output | 32 | {28'b0, overrun, break, parity, framing} |

## Verification
Characters are sent at every data width and in each parity mode, once with a correct and once with an inverted parity bit. A correct tag on one and a wrong tag on the other separates the parity rule from the data path. Frames with a low stop bit are set against frames held low well past a character time. This tells framing from break and confirms that the break yields one zero character and then a lockout. A short low glitch checks start validation. A queue filled past capacity with distinct values shows both the overrun flag and that the stored entries are intact. A clear with all-ones data checks that the tags drop while the data and the upper status bits stay as they were.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRKWAIT
  } rxState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic startShift;
    logic shiftBit;
    logic sampleParity;
    logic finishChar;
    logic pushBreak;
  } rxStrobe_t;

  // one queue entry: character plus its error tags
  typedef struct packed {
    logic [7:0] data;
    logic       brk;
    logic       par;
    logic       frm;
  } rxEntry_t;

  localparam int FLAG_W = 4;

endpackage

// File: rtl/uart_rx_ctrl.sv
`timescale 1ns/1ps
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       lineBit,
  input  logic       charAllLow,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  output rxStrobe_t  str
);

  localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rxState_t   state, nState;
  logic [CW-1:0] tickCnt, nCnt;
  logic [2:0] bitCnt, nBit;
  logic [2:0] lastBit;

  assign lastBit = 3'd4 + {1'b0, wordLen};

  always_comb begin
    nState = state;
    nCnt   = tickCnt;
    nBit   = bitCnt;
    str    = '0;
    if (sampleTick) begin
      nCnt = tickCnt + 1'b1;
      unique case (state)
        RX_IDLE: begin
          if (!lineBit) begin
            nState = RX_START;
            nCnt   = '0;
          end
        end
        RX_START: begin
          if (tickCnt == MID) begin
            nCnt = '0;
            if (!lineBit) begin
              nState         = RX_DATA;
              nBit           = '0;
              str.startShift = 1'b1;
            end else begin
              nState = RX_IDLE;
            end
          end
        end
        RX_DATA: begin
          if (tickCnt == LAST) begin
            nCnt         = '0;
            str.shiftBit = 1'b1;
            if (bitCnt == lastBit) nState = parityEn ? RX_PAR : RX_STOP;
            else                   nBit   = bitCnt + 1'b1;
          end
        end
        RX_PAR: begin
          if (tickCnt == LAST) begin
            nCnt             = '0;
            str.sampleParity = 1'b1;
            nState           = RX_STOP;
          end
        end
        RX_STOP: begin
          if (tickCnt == LAST) begin
            nCnt = '0;
            if (!lineBit && charAllLow) begin
              str.pushBreak = 1'b1;
              nState        = RX_BRKWAIT;
            end else begin
              str.finishChar = 1'b1;
              nState         = RX_IDLE;
            end
          end
        end
        RX_BRKWAIT: begin
          if (lineBit) nState = RX_IDLE;
        end
        default: nState = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= nState;
      tickCnt <= nCnt;
      bitCnt  <= nBit;
    end
  end

  // R1: a high sample at the start midpoint abandons the character
  a_r1_start_reject: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && sampleTick && tickCnt == MID && lineBit) |=> state == RX_IDLE);

  // R7: lockout holds until the line is sampled high
  a_r7_break_lockout: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_BRKWAIT && !(sampleTick && lineBit)) |=> state == RX_BRKWAIT);

endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  rxEntry_t wrData,
  input  logic     rdEn,
  input  logic     clrHead,
  output rxEntry_t head,
  output logic     empty,
  output logic     full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rxEntry_t mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic doWr, doRd;

  assign doWr  = wrEn && !full;
  assign doRd  = rdEn && !empty;
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rdPtr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= bump(wrPtr);
      if (doRd) rdPtr <= bump(rdPtr);
      unique case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // clear first, so a write into the same slot keeps its own tags
  always_ff @(posedge clk) begin
    if (clrHead && !empty) begin
      mem[rdPtr].brk <= 1'b0;
      mem[rdPtr].par <= 1'b0;
      mem[rdPtr].frm <= 1'b0;
    end
    if (doWr) mem[wrPtr] <= wrData;
  end

  // R6: a break entry carries zero data and only the break tag
  a_r6_break_char_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData.brk) |-> (wrData.data == 8'h00 && !wrData.par && !wrData.frm));

  // R9: a write into a full queue leaves it full and unchanged
  a_r9_keep_contents: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrEn && !rdEn) |=> (full && $stable(rdPtr)));

endmodule

// File: rtl/uart_rx_datapath.sv
`timescale 1ns/1ps
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobe_t         str,
  input  logic [1:0]        wordLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              parityStick,
  input  logic              rdEn,
  input  logic              errClrWr,
  output logic              lineBit,
  output logic              charAllLow,
  output logic [7:0]        rxData,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic [FLAG_W-1:0] flags
);

  logic [1:0] syncQ;
  logic [7:0] shReg;
  logic       parBit;
  logic       seenHigh;
  logic       overrun;
  logic       charDone;
  logic [7:0] alignedData;
  logic       expPar;
  rxEntry_t   newEntry, headEntry;

  // two-flop synchronizer, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end
  assign lineBit = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      parBit   <= 1'b0;
      seenHigh <= 1'b0;
    end else begin
      if (str.startShift) begin
        shReg    <= '0;
        seenHigh <= 1'b0;
      end
      if (str.shiftBit) begin
        shReg <= {lineBit, shReg[7:1]};
        if (lineBit) seenHigh <= 1'b1;
      end
      if (str.sampleParity) begin
        parBit <= lineBit;
        if (lineBit) seenHigh <= 1'b1;
      end
    end
  end
  assign charAllLow = !seenHigh;

  // bits entered from the top: shift down by the unused width
  assign alignedData = shReg >> (2'd3 - wordLen);
  assign expPar      = parityStick ? parityOdd : ((^alignedData) ^ parityOdd);

  always_comb begin
    newEntry = '0;
    if (str.pushBreak) begin
      newEntry.brk = 1'b1;
    end else begin
      newEntry.data = alignedData;
      newEntry.par  = parityEn && (parBit != expPar);
      newEntry.frm  = !lineBit;
    end
  end

  assign charDone = str.finishChar | str.pushBreak;

  uart_rx_fifo #(.DEPTH(DEPTH)) uFifo (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (charDone),
    .wrData  (newEntry),
    .rdEn    (rdEn),
    .clrHead (errClrWr),
    .head    (headEntry),
    .empty   (rxEmpty),
    .full    (rxFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  overrun <= 1'b0;
    else if (charDone && rxFull) overrun <= 1'b1;
    else if (errClrWr)           overrun <= 1'b0;
  end

  assign rxData = headEntry.data;
  assign flags  = {overrun,
                   headEntry.brk & !rxEmpty,
                   headEntry.par & !rxEmpty,
                   headEntry.frm & !rxEmpty};

  // R9: completing into a full queue raises overrun
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (charDone && rxFull) |=> overrun);

  // R10: a clear write with no concurrent queue change empties all flags
  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (errClrWr && !rdEn && !charDone) |=> (flags == '0));

endmodule

// File: rtl/uart_rx_top.sv
`timescale 1ns/1ps
module uart_rx_top
  import uart_rx_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int OSR      = 16,
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleTick,
  input  logic                rxLine,
  input  logic [1:0]          wordLen,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                parityStick,
  input  logic                rdEn,
  output logic [7:0]          rxData,
  output logic                rxEmpty,
  output logic                rxFull,
  input  logic                errClrWr,
  input  logic [STATUS_W-1:0] errClrData,
  output logic [STATUS_W-1:0] statusWord
);

  rxStrobe_t         str;
  logic              lineBit;
  logic              charAllLow;
  logic [FLAG_W-1:0] flags;
  logic              unusedClrData;

  // the clear port acts on the strobe alone
  assign unusedClrData = ^errClrData;

  uart_rx_ctrl #(.OSR(OSR)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .lineBit    (lineBit),
    .charAllLow (charAllLow),
    .wordLen    (wordLen),
    .parityEn   (parityEn),
    .str        (str)
  );

  uart_rx_datapath #(.DEPTH(DEPTH)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .str         (str),
    .wordLen     (wordLen),
    .parityEn    (parityEn),
    .parityOdd   (parityOdd),
    .parityStick (parityStick),
    .rdEn        (rdEn),
    .errClrWr    (errClrWr),
    .lineBit     (lineBit),
    .charAllLow  (charAllLow),
    .rxData      (rxData),
    .rxEmpty     (rxEmpty),
    .rxFull      (rxFull),
    .flags       (flags)
  );

  assign statusWord = {{(STATUS_W - FLAG_W){1'b0}}, flags};

endmodule

// File: tb/tb_uart_rx_top.sv
`timescale 1ns/1ps
module tb_uart_rx_top;

  localparam int DEPTH    = 8;
  localparam int OSR      = 16;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = OSR * TICK_DIV;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleTick = 1'b0;
  logic        rxLine = 1'b1;
  logic [1:0]  wordLen = 2'd3;
  logic        parityEn = 1'b0;
  logic        parityOdd = 1'b0;
  logic        parityStick = 1'b0;
  logic        rdEn = 1'b0;
  logic        errClrWr = 1'b0;
  logic [31:0] errClrData = '0;
  logic [7:0]  rxData;
  logic        rxEmpty, rxFull;
  logic [31:0] statusWord;

  int checks = 0;
  int fails  = 0;
  bit monEn  = 1'b1;
  string curReq = "R2";
  logic [10:0] expQ [$];   // {data, brk, par, frm}

  uart_rx_top #(.DEPTH(DEPTH), .OSR(OSR)) dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .wordLen(wordLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .parityStick(parityStick), .rdEn(rdEn), .rxData(rxData),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .errClrWr(errClrWr),
    .errClrData(errClrData), .statusWord(statusWord)
  );

  always #4 clk = ~clk;

  int divCnt = 0;
  always @(posedge clk) begin
    divCnt     <= (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    sampleTick <= (divCnt == TICK_DIV - 1);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic waitClks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic v, input int ticks);
    rxLine = v;
    waitClks(ticks * TICK_DIV);
  endtask

  // drives one frame with the current format; queues its expected entry
  task automatic sendFrame(input logic [7:0] d, input bit badPar,
                           input bit badStop, input bit expect_it);
    int n;
    logic [7:0] m;
    logic pb;
    n  = 5 + int'(wordLen);
    m  = d & 8'((9'd1 << n) - 1);
    pb = parityStick ? parityOdd : ((^m) ^ parityOdd);
    sendBit(1'b0, OSR);
    for (int i = 0; i < n; i++) sendBit(m[i], OSR);
    if (parityEn) sendBit(pb ^ badPar, OSR);
    if (expect_it) expQ.push_back({m, 1'b0, parityEn && badPar, badStop});
    if (badStop) begin
      sendBit(1'b0, 11);
      sendBit(1'b1, 2 * OSR);
    end else begin
      sendBit(1'b1, OSR + 4);
    end
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0 || !rxEmpty) @(negedge clk);
    waitClks(4);
  endtask

  task automatic pulseClear(input logic [31:0] v);
    errClrData = v;
    errClrWr   = 1'b1;
    @(negedge clk);
    errClrWr   = 1'b0;
    errClrData = '0;
  endtask

  // scoreboard monitor: compares the head with the oldest expected entry
  initial begin
    logic [10:0] e;
    forever begin
      @(negedge clk);
      if (monEn && !rxEmpty) begin
        if (expQ.size() == 0) begin
          check(1'b0, curReq, "unexpected character", {21'd0, rxData, statusWord[2:0]}, 32'd0);
        end else begin
          e = expQ.pop_front();
          check({rxData, statusWord[2:0]} == e, curReq, "head data/tags",
                {21'd0, rxData, statusWord[2:0]}, {21'd0, e});
        end
        rdEn = 1'b1;
        @(negedge clk);
        rdEn = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    waitClks(5);
    // R11: reset state
    check(rxEmpty == 1'b1, "R11", "empty after reset", {31'd0, rxEmpty}, 32'd1);
    check(statusWord == 32'd0, "R11", "status after reset", statusWord, 32'd0);
    rstN = 1'b1;
    waitClks(BIT_CLKS);

    // R2: 8-bit characters, then narrower widths
    curReq = "R2";
    sendFrame(8'hA5, 0, 0, 1);
    sendFrame(8'h3C, 0, 0, 1);
    for (int w = 0; w < 3; w++) begin
      wordLen = 2'(w);
      sendFrame(8'hFF, 0, 0, 1);
      sendFrame(8'h96, 0, 0, 1);
    end
    waitDrain();

    // R3: even and odd parity, good and bad
    curReq = "R3";
    wordLen = 2'd3;
    parityEn = 1'b1;
    parityOdd = 1'b0;
    sendFrame(8'h71, 0, 0, 1);
    sendFrame(8'h71, 1, 0, 1);
    parityOdd = 1'b1;
    sendFrame(8'h0E, 0, 0, 1);
    sendFrame(8'h0E, 1, 0, 1);
    waitDrain();

    // R4: stick parity levels
    curReq = "R4";
    parityStick = 1'b1;
    parityOdd = 1'b0;
    sendFrame(8'hC3, 0, 0, 1);
    sendFrame(8'hC3, 1, 0, 1);
    parityOdd = 1'b1;
    sendFrame(8'h42, 0, 0, 1);
    sendFrame(8'h42, 1, 0, 1);
    waitDrain();
    parityStick = 1'b0;
    parityEn = 1'b0;
    parityOdd = 1'b0;

    // R5: low stop bit
    curReq = "R5";
    sendFrame(8'h55, 0, 1, 1);
    waitDrain();

    // R1: short low glitch must not start a character
    curReq = "R1";
    rxLine = 1'b0;
    waitClks(3 * TICK_DIV);
    rxLine = 1'b1;
    waitClks(3 * BIT_CLKS);
    check(rxEmpty == 1'b1, "R1", "glitch stored nothing", {31'd0, rxEmpty}, 32'd1);

    // R6: long low line gives one zero break character
    curReq = "R6";
    expQ.push_back({8'h00, 3'b100});
    rxLine = 1'b0;
    waitClks(30 * BIT_CLKS);
    rxLine = 1'b1;
    waitClks(2 * BIT_CLKS);
    waitDrain();
    check(rxEmpty == 1'b1, "R7", "no extra character after break", {31'd0, rxEmpty}, 32'd1);

    // R7: reception resumes with a fresh start bit
    curReq = "R7";
    sendFrame(8'h81, 0, 0, 1);
    waitDrain();

    // R10: clear keeps data, drops tags; R11 upper bits stay 0
    monEn = 1'b0;
    parityEn = 1'b1;
    sendFrame(8'h5A, 1, 0, 0);
    waitClks(8);
    check(statusWord[1] == 1'b1, "R3", "parity tag at head", statusWord, 32'h2);
    pulseClear(32'hFFFF_FFFF);
    check(statusWord == 32'd0, "R10", "status after clear", statusWord, 32'd0);
    check(statusWord[31:4] == 28'd0, "R11", "upper bits after all-ones write", statusWord, 32'd0);
    check(rxData == 8'h5A, "R10", "data kept after clear", {24'd0, rxData}, 32'h5A);
    parityEn = 1'b0;
    curReq = "R10";
    expQ.push_back({8'h5A, 3'b000});
    monEn = 1'b1;
    waitDrain();

    // R9: overrun on a full queue
    monEn = 1'b0;
    curReq = "R9";
    for (int i = 0; i < DEPTH + 1; i++) sendFrame(8'(8'h10 + i), 0, 0, i < DEPTH);
    waitClks(8);
    check(rxFull == 1'b1, "R9", "queue full", {31'd0, rxFull}, 32'd1);
    check(statusWord[3] == 1'b1, "R9", "overrun set", statusWord, 32'h8);
    monEn = 1'b1;
    waitDrain();
    check(statusWord[3] == 1'b1, "R9", "overrun sticky", statusWord, 32'h8);
    pulseClear(32'h0);
    check(statusWord == 32'd0, "R10", "overrun cleared", statusWord, 32'd0);

    check(expQ.size() == 0, "R8", "scoreboard drained", expQ.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule